// File: doc/BRIEF.md
# Boot Partition Address Remapper

This block sits between the command engine of an embedded flash card and its backing storage. The storage image holds two equal boot partitions ahead of the user area. The engine issues logical byte addresses that are relative to whichever area the host has selected. The remapper adds the matching physical offset, so that reads and writes share one translated address. It also gives the user-area capacity the engine reports, which is the raw image size less both boot partitions. It also gives the boot size multiplier field, which counts the boot partition size in 128 KiB units.

The partition configuration byte comes from a register file outside the block. Bits [2:0] of that byte select the access area and bits [5:3] enable partition access. Offsets apply only when the device runs in embedded-card mode and the boot partition size is not zero. The translated address is registered: a one-cycle strobe presents a logical address, and the physical address and an error flag appear on the next clock.

Top module: `bootpart_remap`

## Requirements
- R1: When `mmc_mode_i` is 0 or `boot_size_i` is 0, a strobed address passes through with zero offset and `sel_err_o` is 0.
- R2: When the enable field `part_cfg_i[5:3]` is 0, the offset is zero and `sel_err_o` is 0, whatever the access field holds.
- R3: With partitions enabled, access code 0 in `part_cfg_i[2:0]` (user area) adds twice `boot_size_i` to the address.
- R4: With partitions enabled, access code 1 (first boot area) adds zero, and access code 2 (second boot area) adds one `boot_size_i`.
- R5: With partitions enabled, access codes 3 to 7 set `sel_err_o` to 1 and leave the physical address equal to the logical one; a later strobe with a valid code clears `sel_err_o`.
- R6: `phys_vld_o` is high exactly one clock after each cycle in which `req_vld_i` is high; `phys_addr_o` and `sel_err_o` change only after a strobe and hold their values otherwise.
- R7: `user_cap_o` equals `raw_size_i` minus twice `boot_size_i` in embedded-card mode with a nonzero boot size, saturating at 0; otherwise it equals `raw_size_i`.
- R8: `boot_mult_o` equals `boot_size_i` divided by 131072, rounded down and truncated to its width.
- R9: While `rst_ni` is low, `phys_vld_o`, `phys_addr_o` and `sel_err_o` are all 0.
- R10: The physical address is the sum modulo 2^ADDR_W, so it wraps past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Strobe marking a valid logical address |
| log_addr_i | input | ADDR_W | Logical byte address from the command engine |
| boot_size_i | input | ADDR_W | Size of one boot partition in bytes |
| mmc_mode_i | input | 1 | Embedded-card mode; offsets are applied only when set |
| part_cfg_i | input | 8 | Partition configuration byte: access [2:0], enable [5:3] |
| raw_size_i | input | ADDR_W | Raw size of the storage image in bytes |
| phys_vld_o | output | 1 | Physical address valid, one clock after the strobe |
| phys_addr_o | output | ADDR_W | Registered physical byte address |
| sel_err_o | output | 1 | Unsupported access code seen at the last strobe |
| user_cap_o | output | ADDR_W | User-area capacity in bytes |
| boot_mult_o | output | MULT_W | Boot partition size in 128 KiB units |

## Verification
On every cycle the assertions check the strobe-to-valid latency, that the address and error flag hold between strobes, and the pass-through cases: non-embedded mode, the first boot area and unsupported codes. They also check that the capacity never exceeds the raw size and that an error never comes with a nonzero offset. The exact offsets for the user and second boot areas, address wrap, capacity saturation, multiplier truncation and the clearing of the error flag are shown only by the bench's vectors and directed scenarios.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    // Field layout of the partition configuration byte
    localparam int CFG_W   = 8;
    localparam int ACC_LSB = 0;
    localparam int ACC_W   = 3;
    localparam int EN_LSB  = 3;
    localparam int EN_W    = 3;

    // Areas a host may select through the access field
    typedef enum logic [ACC_W-1:0] {
        AREA_USER  = 3'd0,
        AREA_BOOT1 = 3'd1,
        AREA_BOOT2 = 3'd2
    } area_e;

    function automatic logic [ACC_W-1:0] acc_field(input logic [CFG_W-1:0] cfg);
        return cfg[ACC_LSB +: ACC_W];
    endfunction

    function automatic logic [EN_W-1:0] en_field(input logic [CFG_W-1:0] cfg);
        return cfg[EN_LSB +: EN_W];
    endfunction

endpackage

// File: rtl/bootmap_offset_sel.sv
module bootmap_offset_sel
    import bootmap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] boot_size_i,
    input  logic              mmc_mode_i,
    input  logic [5:0]        cfg_i,
    output logic [ADDR_W-1:0] offset_o,
    output logic              sel_err_o
);

    logic [ADDR_W-1:0] twice_size;
    logic [ACC_W-1:0]  acc;
    logic              active;

    assign twice_size = boot_size_i << 1;
    assign acc        = acc_field({2'b00, cfg_i});
    assign active     = mmc_mode_i && (|boot_size_i) && (|en_field({2'b00, cfg_i}));

    always_comb begin
        offset_o  = '0;
        sel_err_o = 1'b0;
        if (active) begin
            case (acc)
                AREA_USER:  offset_o = twice_size;
                AREA_BOOT1: offset_o = '0;
                AREA_BOOT2: offset_o = boot_size_i;
                default:    sel_err_o = 1'b1;
            endcase
        end
    end

    // An unsupported code must leave the address untouched
    always_comb begin
        p_err_no_offset_r5: assert (!sel_err_o || offset_o == '0)
            else $error("offset applied together with a selection error");
    end

endmodule

// File: rtl/bootmap_capacity.sv
module bootmap_capacity #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] raw_size_i,
    input  logic [ADDR_W-1:0] boot_size_i,
    input  logic              mmc_mode_i,
    output logic [ADDR_W-1:0] user_cap_o
);

    localparam int WIDE_W = ADDR_W + 1;

    logic [WIDE_W-1:0] both_parts;
    logic [WIDE_W-1:0] raw_wide;
    logic [WIDE_W-1:0] diff;

    assign both_parts = {boot_size_i, 1'b0};
    assign raw_wide   = {1'b0, raw_size_i};
    assign diff       = raw_wide - both_parts;

    always_comb begin
        if (mmc_mode_i && (|boot_size_i)) begin
            user_cap_o = (both_parts > raw_wide) ? '0 : diff[ADDR_W-1:0];
        end else begin
            user_cap_o = raw_size_i;
        end
    end

    always_comb begin
        p_cap_bound_r7: assert (user_cap_o <= raw_size_i)
            else $error("user capacity above raw size");
    end

endmodule

// File: rtl/bootmap_mult.sv
module bootmap_mult #(
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 17,
    parameter int MULT_W     = 8
) (
    input  logic [ADDR_W-1:0] boot_size_i,
    output logic [MULT_W-1:0] mult_o
);

    localparam int FIELD_TOP = UNIT_SHIFT + MULT_W;

    logic size_unused;
    assign size_unused = ^boot_size_i;

    generate
        if (ADDR_W >= FIELD_TOP) begin : g_full
            assign mult_o = boot_size_i[UNIT_SHIFT +: MULT_W];
        end else if (ADDR_W > UNIT_SHIFT) begin : g_part
            assign mult_o = MULT_W'(boot_size_i[ADDR_W-1:UNIT_SHIFT]);
        end else begin : g_none
            assign mult_o = '0;
        end
    endgenerate

endmodule

// File: rtl/bootpart_remap.sv
module bootpart_remap
    import bootmap_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 17,
    parameter int MULT_W     = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_vld_i,
    input  logic [ADDR_W-1:0] log_addr_i,
    input  logic [ADDR_W-1:0] boot_size_i,
    input  logic              mmc_mode_i,
    input  logic [CFG_W-1:0]  part_cfg_i,
    input  logic [ADDR_W-1:0] raw_size_i,
    output logic              phys_vld_o,
    output logic [ADDR_W-1:0] phys_addr_o,
    output logic              sel_err_o,
    output logic [ADDR_W-1:0] user_cap_o,
    output logic [MULT_W-1:0] boot_mult_o
);

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } remap_st_t;

    remap_st_t         st_d, st_q;
    logic [ADDR_W-1:0] offset;
    logic              code_err;
    logic              cfg_unused;

    assign cfg_unused = ^part_cfg_i[CFG_W-1:EN_LSB+EN_W];

    bootmap_offset_sel #(
        .ADDR_W (ADDR_W)
    ) u_offset (
        .boot_size_i (boot_size_i),
        .mmc_mode_i  (mmc_mode_i),
        .cfg_i       (part_cfg_i[EN_LSB+EN_W-1:0]),
        .offset_o    (offset),
        .sel_err_o   (code_err)
    );

    bootmap_capacity #(
        .ADDR_W (ADDR_W)
    ) u_capacity (
        .raw_size_i  (raw_size_i),
        .boot_size_i (boot_size_i),
        .mmc_mode_i  (mmc_mode_i),
        .user_cap_o  (user_cap_o)
    );

    bootmap_mult #(
        .ADDR_W     (ADDR_W),
        .UNIT_SHIFT (UNIT_SHIFT),
        .MULT_W     (MULT_W)
    ) u_mult (
        .boot_size_i (boot_size_i),
        .mult_o      (boot_mult_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_vld_i;
        if (req_vld_i) begin
            st_d.addr = log_addr_i + offset;
            st_d.err  = code_err;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phys_vld_o  = st_q.vld;
    assign phys_addr_o = st_q.addr;
    assign sel_err_o   = st_q.err;

    // Pass-through outside embedded-card mode
    p_plain_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_vld_i && !mmc_mode_i |=> phys_addr_o == $past(log_addr_i) && !sel_err_o);

    // First boot area carries no offset
    p_boot_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_vld_i && mmc_mode_i && (|boot_size_i) && (|en_field(part_cfg_i))
        && acc_field(part_cfg_i) == 3'd1
        |=> phys_addr_o == $past(log_addr_i));

    // Unsupported codes flag an error and pass the address through
    p_bad_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_vld_i && mmc_mode_i && (|boot_size_i) && (|en_field(part_cfg_i))
        && acc_field(part_cfg_i) > 3'd2
        |=> sel_err_o && phys_addr_o == $past(log_addr_i));

    p_valid_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_vld_i |=> phys_vld_o);

    p_no_spurious_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_vld_i |=> !phys_vld_o);

    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_vld_i |=> $stable(phys_addr_o) && $stable(sel_err_o));

endmodule

// File: tb/bootpart_remap_test.sv
module bootpart_remap_test;

    localparam int ADDR_W = 32;
    localparam int MULT_W = 8;
    localparam int NVEC   = 15;

    typedef struct packed {
        logic [31:0] laddr;
        logic [31:0] bsize;
        logic        mmc;
        logic [7:0]  cfg;
        logic [31:0] raw;
        logic [31:0] exp_addr;
        logic        exp_err;
        logic [31:0] exp_cap;
        logic [7:0]  exp_mult;
        logic [3:0]  req;
    } vec_t;

    // laddr, bsize, mmc, cfg, raw, exp_addr, exp_err, exp_cap, exp_mult, req
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 32'h0002_0000, 1'b0, 8'h08, 32'h0100_0000, 32'h0000_1000, 1'b0, 32'h0100_0000, 8'd1, 4'd1},
        '{32'h0000_1000, 32'h0000_0000, 1'b1, 8'h08, 32'h0100_0000, 32'h0000_1000, 1'b0, 32'h0100_0000, 8'd0, 4'd1},
        '{32'h0000_1000, 32'h0002_0000, 1'b1, 8'h00, 32'h0100_0000, 32'h0000_1000, 1'b0, 32'h00FC_0000, 8'd1, 4'd2},
        '{32'h0000_1000, 32'h0002_0000, 1'b1, 8'h08, 32'h0100_0000, 32'h0004_1000, 1'b0, 32'h00FC_0000, 8'd1, 4'd3},
        '{32'h0000_0000, 32'h0010_0000, 1'b1, 8'h38, 32'h0100_0000, 32'h0020_0000, 1'b0, 32'h00E0_0000, 8'd8, 4'd3},
        '{32'h0000_2345, 32'h0002_0000, 1'b1, 8'h09, 32'h0100_0000, 32'h0000_2345, 1'b0, 32'h00FC_0000, 8'd1, 4'd4},
        '{32'h0000_2345, 32'h0002_0000, 1'b1, 8'h0A, 32'h0100_0000, 32'h0002_2345, 1'b0, 32'h00FC_0000, 8'd1, 4'd4},
        '{32'h0000_2345, 32'h0010_0000, 1'b1, 8'h12, 32'h0100_0000, 32'h0010_2345, 1'b0, 32'h00E0_0000, 8'd8, 4'd4},
        '{32'h0000_5000, 32'h0002_0000, 1'b1, 8'h0B, 32'h0100_0000, 32'h0000_5000, 1'b1, 32'h00FC_0000, 8'd1, 4'd5},
        '{32'h0000_5000, 32'h0002_0000, 1'b1, 8'h0F, 32'h0100_0000, 32'h0000_5000, 1'b1, 32'h00FC_0000, 8'd1, 4'd5},
        '{32'h0000_5000, 32'h0002_0000, 1'b1, 8'h03, 32'h0100_0000, 32'h0000_5000, 1'b0, 32'h00FC_0000, 8'd1, 4'd2},
        '{32'hFFFF_F000, 32'h0002_0000, 1'b1, 8'h08, 32'h0100_0000, 32'h0003_F000, 1'b0, 32'h00FC_0000, 8'd1, 4'd10},
        '{32'h0000_0010, 32'h0002_0000, 1'b1, 8'h09, 32'h0003_0000, 32'h0000_0010, 1'b0, 32'h0000_0000, 8'd1, 4'd7},
        '{32'h0000_0001, 32'h0003_FFFF, 1'b1, 8'h0A, 32'h0100_0000, 32'h0004_0000, 1'b0, 32'h00F8_0002, 8'd1, 4'd8},
        '{32'h0000_0000, 32'h0200_0000, 1'b1, 8'h08, 32'h1000_0000, 32'h0400_0000, 1'b0, 32'h0C00_0000, 8'd0, 4'd8}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_vld = 1'b0;
    logic [ADDR_W-1:0] log_addr = '0;
    logic [ADDR_W-1:0] boot_size = '0;
    logic              mmc_mode = 1'b0;
    logic [7:0]        part_cfg = '0;
    logic [ADDR_W-1:0] raw_size = '0;
    logic              phys_vld;
    logic [ADDR_W-1:0] phys_addr;
    logic              sel_err;
    logic [ADDR_W-1:0] user_cap;
    logic [MULT_W-1:0] boot_mult;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    bootpart_remap #(
        .ADDR_W (ADDR_W)
    ) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_vld_i   (req_vld),
        .log_addr_i  (log_addr),
        .boot_size_i (boot_size),
        .mmc_mode_i  (mmc_mode),
        .part_cfg_i  (part_cfg),
        .raw_size_i  (raw_size),
        .phys_vld_o  (phys_vld),
        .phys_addr_o (phys_addr),
        .sel_err_o   (sel_err),
        .user_cap_o  (user_cap),
        .boot_mult_o (boot_mult)
    );

    function automatic string tag_name(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] la, input logic [31:0] bs, input logic m,
                         input logic [7:0] c, input logic [31:0] rs, input logic strobe);
        @(negedge clk);
        log_addr  = la;
        boot_size = bs;
        mmc_mode  = m;
        part_cfg  = c;
        raw_size  = rs;
        req_vld   = strobe;
        @(negedge clk);
        req_vld   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: outputs cleared while reset is held
        repeat (3) @(negedge clk);
        check("R9", "vld in reset",  32'(phys_vld),  32'd0);
        check("R9", "addr in reset", phys_addr,      32'd0);
        check("R9", "err in reset",  32'(sel_err),   32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].laddr, VECS[i].bsize, VECS[i].mmc, VECS[i].cfg, VECS[i].raw, 1'b1);
            check(tag_name(VECS[i].req), "addr",  phys_addr, VECS[i].exp_addr);
            check(tag_name(VECS[i].req), "err",   32'(sel_err), 32'(VECS[i].exp_err));
            check("R6", "vld after strobe",       32'(phys_vld), 32'd1);
            check("R7", "capacity",                user_cap,  VECS[i].exp_cap);
            check("R8", "multiplier",              32'(boot_mult), 32'(VECS[i].exp_mult));
        end

        // R6: valid is low in the strobe cycle and rises one clock later
        @(negedge clk);
        log_addr = 32'h0000_0100; boot_size = 32'h0002_0000; mmc_mode = 1'b1;
        part_cfg = 8'h0A; raw_size = 32'h0100_0000; req_vld = 1'b1;
        #1;
        check("R6", "vld before edge", 32'(phys_vld), 32'd0);
        @(negedge clk);
        req_vld = 1'b0;
        check("R6", "vld after edge",  32'(phys_vld), 32'd1);
        check("R4", "second boot area", phys_addr, 32'h0002_0100);

        // R6: inputs change without a strobe; address and flag hold
        log_addr = 32'h0000_7777; part_cfg = 8'h0B;
        repeat (2) @(negedge clk);
        check("R6", "addr held", phys_addr, 32'h0002_0100);
        check("R6", "err held",  32'(sel_err), 32'd0);
        check("R6", "vld drops", 32'(phys_vld), 32'd0);

        // R5: error raised, held without strobe, cleared by a valid code
        drive(32'h0000_0040, 32'h0002_0000, 1'b1, 8'h0D, 32'h0100_0000, 1'b1);
        check("R5", "err raised", 32'(sel_err), 32'd1);
        part_cfg = 8'h08;
        repeat (2) @(negedge clk);
        check("R5", "err held",   32'(sel_err), 32'd1);
        drive(32'h0000_0040, 32'h0002_0000, 1'b1, 8'h08, 32'h0100_0000, 1'b1);
        check("R5", "err cleared", 32'(sel_err), 32'd0);
        check("R3", "user area after error", phys_addr, 32'h0004_0040);

        // R1: non-embedded mode ignores an unsupported code
        drive(32'h0000_0800, 32'h0002_0000, 1'b0, 8'h0F, 32'h0100_0000, 1'b1);
        check("R1", "no error off mode", 32'(sel_err), 32'd0);
        check("R1", "addr off mode",     phys_addr, 32'h0000_0800);

        // R9: asynchronous reset mid-run
        #1;
        rst_n = 1'b0;
        #1;
        check("R9", "addr after reset", phys_addr, 32'd0);
        check("R9", "vld after reset",  32'(phys_vld), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule